// File: doc/BRIEF.md
# Multiplexed GPIO Bank Controller

The block is a bank of general-purpose I/O pins behind a small word-addressed register port (address, write data, write strobe, combinational read data), clocked by one clock. Each pin is either owned by the GPIO logic or handed to one of four internal peripheral functions. Pins owned by GPIO can be driven push-pull or open-drain. Pins handed to a peripheral take their value and enable from the function that the pin's two-bit selector picks.

Almost every per-pin attribute has a set register and a clear register. Writing a 1 to a bit changes only that pin, and a 0 bit leaves the pin alone. A status address reads each attribute back. The peripheral selector is split across two plain read/write registers, one for the low bit of the code and one for the high bit. A plain read/write register also holds the Schmitt-trigger disable bits. The pad inputs pass through a two-flop synchronizer into a pin-data status word. That word is readable for every pin, whoever owns the pin.

Attribute k (own=0, output enable=1, output data=2, pull-up=3, pull-down=4, multi-drive=5, filter enable=6) sits at word addresses 3k (set), 3k+1 (clear) and 3k+2 (status). The remaining registers are:

- selector low bit at address 21
- selector high bit at address 22
- Schmitt disable at address 23
- pin data at address 24

Top module: `gpio_bank`

## Requirements
- R1: After reset the registers hold these values:
  - ownership: all ones
  - output enable, output data, pull-down, multi-drive, filter enable: zero
  - pull-up: all ones
  - both selector registers and the Schmitt register: zero
  - pin data: zero
- R2: A write to an attribute's set address (3k) sets exactly the pins whose write-data bit is 1. A write to its clear address (3k+1) clears exactly those pins. A 0 bit leaves the pin unchanged. The status address (3k+2) returns the attribute. filter_en_o follows the filter attribute (k=6).
- R3: A pin never has pull-up and pull-down active together. Setting pull-up clears pull-down on the same pins, and setting pull-down clears pull-up. pad_pu_o and pad_pd_o follow the two attributes.
- R4: On a pin whose ownership bit is 0, pad_out_o and pad_oe_o come from the peripheral function chosen by the code {sel_hi, sel_lo}: 0=A, 1=B, 2=C, 3=D. Function f uses bits [f*32+p] of periph_out_i and periph_oe_i.
- R5: On a GPIO-owned pin with multi-drive off, pad_out_o equals the output-data bit and pad_oe_o equals the output-enable bit.
- R6: On a GPIO-owned pin with multi-drive on, pad_out_o is 0. pad_oe_o is the output-enable bit with the pad released (0) whenever the data bit is 1.
- R7: The pin-data register (address 24) shows pad_in_i as sampled two rising clock edges earlier, for owned and unowned pins alike.
- R8: The selector registers (21, 22) and the Schmitt register (23) are plain read/write. pad_st_dis_o follows the Schmitt register, where 1 disables the trigger.
- R9: Reads of set addresses, clear addresses and unmapped addresses (25 to 31) return 0. Writes to status addresses (3k+2 and 24) change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | ADDR_W (5) | Register word address |
| wdata_i | input | NUM_PINS (32) | Write data, one bit per pin |
| we_i | input | 1 | Write strobe |
| rdata_o | output | NUM_PINS (32) | Read data for addr_i |
| pad_in_i | input | NUM_PINS | Pad input levels |
| pad_out_o | output | NUM_PINS | Pad output value |
| pad_oe_o | output | NUM_PINS | Pad output enable |
| pad_pu_o | output | NUM_PINS | Pull-up enable |
| pad_pd_o | output | NUM_PINS | Pull-down enable |
| pad_st_dis_o | output | NUM_PINS | Schmitt-trigger disable |
| filter_en_o | output | NUM_PINS | Input-filter enable |
| periph_out_i | input | 4*NUM_PINS | Peripheral output values, function f at [f*NUM_PINS +: NUM_PINS] |
| periph_oe_i | input | 4*NUM_PINS | Peripheral output enables, same layout |

## Verification
The bench builds the bank with its default parameters: 32 pins, a 5-bit address and a two-stage synchronizer. This makes the full register map reachable, including the unmapped top addresses. It also allows a single word of the bench to mix unowned pins on all four selector codes with push-pull and open-drain GPIO pins. The two-stage setting lets the bench observe the pin-data word both one edge after a pad change (still the old value) and two edges after it (the new value).

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned NUM_ATTR = 7;
  localparam int unsigned NUM_FUNC = 4;
  localparam int unsigned SEL_W    = 2;

  typedef enum int unsigned {
    ATTR_OWN = 0,
    ATTR_OE  = 1,
    ATTR_DO  = 2,
    ATTR_PU  = 3,
    ATTR_PD  = 4,
    ATTR_MD  = 5,
    ATTR_FLT = 6
  } attr_e;

  localparam int unsigned ADDR_SEL_LO = 21;
  localparam int unsigned ADDR_SEL_HI = 22;
  localparam int unsigned ADDR_SCHM   = 23;
  localparam int unsigned ADDR_PIN    = 24;
  localparam int unsigned ADDR_LAST   = 24;

  function automatic int unsigned set_addr(int unsigned k);
    return 3 * k;
  endfunction

  function automatic int unsigned clr_addr(int unsigned k);
    return 3 * k + 1;
  endfunction

  function automatic int unsigned stat_addr(int unsigned k);
    return 3 * k + 2;
  endfunction

  function automatic logic attr_rst_one(int unsigned k);
    return (k == ATTR_OWN) || (k == ATTR_PU);
  endfunction
endpackage

// File: rtl/gpio_attr_reg.sv
module gpio_attr_reg #(
  parameter int unsigned    W       = 32,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_we_i,
  input  logic         clr_we_i,
  input  logic         xclr_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_d;

  always_comb begin
    q_d = q_o;
    if (set_we_i) q_d = q_d | wdata_i;
    if (clr_we_i || xclr_we_i) q_d = q_d & ~wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= RST_VAL;
    else         q_o <= q_d;
  end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
  import gpio_bank_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0]          own_i,
  input  logic [W-1:0]          oe_i,
  input  logic [W-1:0]          do_i,
  input  logic [W-1:0]          md_i,
  input  logic [W-1:0]          sel_lo_i,
  input  logic [W-1:0]          sel_hi_i,
  input  logic [NUM_FUNC*W-1:0] periph_out_i,
  input  logic [NUM_FUNC*W-1:0] periph_oe_i,
  output logic [W-1:0]          pad_out_o,
  output logic [W-1:0]          pad_oe_o
);
  for (genvar p = 0; p < W; p++) begin : g_pin
    logic [NUM_FUNC-1:0] cand_out;
    logic [NUM_FUNC-1:0] cand_oe;
    logic [SEL_W-1:0]    code;
    logic                gpio_out;
    logic                gpio_oe;

    for (genvar f = 0; f < NUM_FUNC; f++) begin : g_func
      assign cand_out[f] = periph_out_i[f*W + p];
      assign cand_oe[f]  = periph_oe_i[f*W + p];
    end

    assign code = {sel_hi_i[p], sel_lo_i[p]};

    // open drain: drive low only, release on data 1
    assign gpio_out = md_i[p] ? 1'b0 : do_i[p];
    assign gpio_oe  = md_i[p] ? (oe_i[p] & ~do_i[p]) : oe_i[p];

    assign pad_out_o[p] = own_i[p] ? gpio_out : cand_out[code];
    assign pad_oe_o[p]  = own_i[p] ? gpio_oe  : cand_oe[code];
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 32,
  parameter int unsigned ADDR_W      = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [NUM_PINS-1:0]        wdata_i,
  input  logic                       we_i,
  output logic [NUM_PINS-1:0]        rdata_o,
  input  logic [NUM_PINS-1:0]        pad_in_i,
  output logic [NUM_PINS-1:0]        pad_out_o,
  output logic [NUM_PINS-1:0]        pad_oe_o,
  output logic [NUM_PINS-1:0]        pad_pu_o,
  output logic [NUM_PINS-1:0]        pad_pd_o,
  output logic [NUM_PINS-1:0]        pad_st_dis_o,
  output logic [NUM_PINS-1:0]        filter_en_o,
  input  logic [NUM_FUNC*NUM_PINS-1:0] periph_out_i,
  input  logic [NUM_FUNC*NUM_PINS-1:0] periph_oe_i
);
  localparam int unsigned MAX_ADDR = (1 << ADDR_W) - 1;

  initial begin
    if (MAX_ADDR < ADDR_LAST) $display("gpio_bank: ADDR_W too small for register map");
  end

  function automatic logic hit(logic [ADDR_W-1:0] a, int unsigned target);
    return a == ADDR_W'(target);
  endfunction

  logic [NUM_PINS-1:0] attr_q [NUM_ATTR];
  logic [NUM_PINS-1:0] sel_lo_q, sel_hi_q, schm_q;
  logic [NUM_PINS-1:0] pin_q;
  logic [NUM_PINS-1:0] own_q, oe_q, do_q, pu_q, pd_q, md_q, flt_q;

  // set/clear attribute registers
  for (genvar k = 0; k < NUM_ATTR; k++) begin : g_attr
    logic set_we, clr_we, xclr_we;

    assign set_we = we_i && hit(addr_i, set_addr(k));
    assign clr_we = we_i && hit(addr_i, clr_addr(k));

    if (k == ATTR_PU) begin : g_xpu
      assign xclr_we = we_i && hit(addr_i, set_addr(ATTR_PD));
    end else if (k == ATTR_PD) begin : g_xpd
      assign xclr_we = we_i && hit(addr_i, set_addr(ATTR_PU));
    end else begin : g_xnone
      assign xclr_we = 1'b0;
    end

    gpio_attr_reg #(
      .W       (NUM_PINS),
      .RST_VAL (attr_rst_one(k) ? {NUM_PINS{1'b1}} : {NUM_PINS{1'b0}})
    ) u_reg (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .set_we_i  (set_we),
      .clr_we_i  (clr_we),
      .xclr_we_i (xclr_we),
      .wdata_i   (wdata_i),
      .q_o       (attr_q[k])
    );
  end

  assign own_q = attr_q[ATTR_OWN];
  assign oe_q  = attr_q[ATTR_OE];
  assign do_q  = attr_q[ATTR_DO];
  assign pu_q  = attr_q[ATTR_PU];
  assign pd_q  = attr_q[ATTR_PD];
  assign md_q  = attr_q[ATTR_MD];
  assign flt_q = attr_q[ATTR_FLT];

  // plain read/write registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_lo_q <= '0;
      sel_hi_q <= '0;
      schm_q   <= '0;
    end else if (we_i) begin
      if (hit(addr_i, ADDR_SEL_LO)) sel_lo_q <= wdata_i;
      if (hit(addr_i, ADDR_SEL_HI)) sel_hi_q <= wdata_i;
      if (hit(addr_i, ADDR_SCHM))   schm_q   <= wdata_i;
    end
  end

  gpio_in_sync #(
    .W      (NUM_PINS),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pad_in_i),
    .q_o    (pin_q)
  );

  gpio_pin_mux #(
    .W (NUM_PINS)
  ) u_mux (
    .own_i        (own_q),
    .oe_i         (oe_q),
    .do_i         (do_q),
    .md_i         (md_q),
    .sel_lo_i     (sel_lo_q),
    .sel_hi_i     (sel_hi_q),
    .periph_out_i (periph_out_i),
    .periph_oe_i  (periph_oe_i),
    .pad_out_o    (pad_out_o),
    .pad_oe_o     (pad_oe_o)
  );

  // read mux: only status views and plain registers return data
  always_comb begin
    rdata_o = '0;
    for (int unsigned k = 0; k < NUM_ATTR; k++) begin
      if (hit(addr_i, stat_addr(k))) rdata_o = attr_q[k];
    end
    if (hit(addr_i, ADDR_SEL_LO)) rdata_o = sel_lo_q;
    if (hit(addr_i, ADDR_SEL_HI)) rdata_o = sel_hi_q;
    if (hit(addr_i, ADDR_SCHM))   rdata_o = schm_q;
    if (hit(addr_i, ADDR_PIN))    rdata_o = pin_q;
  end

  assign pad_pu_o     = pu_q;
  assign pad_pd_o     = pd_q;
  assign pad_st_dis_o = schm_q;
  assign filter_en_o  = flt_q;
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32,
  parameter int unsigned ADDR_W   = 5
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                we_i,
  input logic [ADDR_W-1:0]   addr_i,
  input logic [NUM_PINS-1:0] wdata_i,
  input logic [NUM_PINS-1:0] pad_in_i,
  input logic [NUM_PINS-1:0] pad_out_o,
  input logic [NUM_PINS-1:0] pad_oe_o,
  input logic [NUM_PINS-1:0] pad_pu_o,
  input logic [NUM_PINS-1:0] pad_pd_o,
  input logic [NUM_PINS-1:0] own_q,
  input logic [NUM_PINS-1:0] oe_q,
  input logic [NUM_PINS-1:0] do_q,
  input logic [NUM_PINS-1:0] md_q,
  input logic [NUM_PINS-1:0] pu_q,
  input logic [NUM_PINS-1:0] pd_q,
  input logic [NUM_PINS-1:0] pin_q
);
  logic [1:0] cyc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cyc_q <= '0;
    else if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
  end

  p_set_bits_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_W'(set_addr(ATTR_DO))) |=>
      (((do_q & $past(wdata_i)) == $past(wdata_i)) &&
       ((do_q & ~$past(wdata_i)) == ($past(do_q) & ~$past(wdata_i)))));

  p_clr_bits_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_W'(clr_addr(ATTR_OE))) |=>
      (((oe_q & $past(wdata_i)) == '0) &&
       ((oe_q & ~$past(wdata_i)) == ($past(oe_q) & ~$past(wdata_i)))));

  p_pull_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pu_q & pd_q) == '0);

  p_pull_pad_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_pu_o & pad_pd_o) == '0);

  p_od_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_out_o & own_q & md_q) == '0);

  p_od_release_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_oe_o & own_q & md_q & do_q) == '0);

  p_sync_lat_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 2'd2) |-> (pin_q == $past(pad_in_i, 2)));

  p_stat_ro_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_W'(stat_addr(ATTR_OE))) |=> $stable(oe_q));
endmodule

bind gpio_bank gpio_bank_chk #(
  .NUM_PINS (NUM_PINS),
  .ADDR_W   (ADDR_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .pad_in_i  (pad_in_i),
  .pad_out_o (pad_out_o),
  .pad_oe_o  (pad_oe_o),
  .pad_pu_o  (pad_pu_o),
  .pad_pd_o  (pad_pd_o),
  .own_q     (own_q),
  .oe_q      (oe_q),
  .do_q      (do_q),
  .md_q      (md_q),
  .pu_q      (pu_q),
  .pd_q      (pd_q),
  .pin_q     (pin_q)
);

// File: tb/tb_gpio_bank.sv
module tb_gpio_bank;
  localparam int N = 32;
  localparam int AW = 5;

  // address map
  localparam int A_OWN_S = 0,  A_OWN_C = 1,  A_OWN_R = 2;
  localparam int A_OE_S  = 3,  A_OE_C  = 4,  A_OE_R  = 5;
  localparam int A_DO_S  = 6,  A_DO_C  = 7,  A_DO_R  = 8;
  localparam int A_PU_S  = 9,  A_PU_C  = 10, A_PU_R  = 11;
  localparam int A_PD_S  = 12, A_PD_C  = 13, A_PD_R  = 14;
  localparam int A_MD_S  = 15, A_MD_C  = 16, A_MD_R  = 17;
  localparam int A_FL_S  = 18, A_FL_C  = 19, A_FL_R  = 20;
  localparam int A_SLO = 21, A_SHI = 22, A_SCH = 23, A_PIN = 24;

  logic clk = 0;
  logic rst_n = 0;
  logic [AW-1:0] addr = '0;
  logic [N-1:0] wdata = '0;
  logic we = 0;
  logic [N-1:0] rdata, pad_in = '0;
  logic [N-1:0] pad_out, pad_oe, pad_pu, pad_pd, pad_st, flt_en;
  logic [4*N-1:0] p_out, p_oe;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  gpio_bank dut (
    .clk_i (clk), .rst_ni (rst_n), .addr_i (addr), .wdata_i (wdata), .we_i (we),
    .rdata_o (rdata), .pad_in_i (pad_in), .pad_out_o (pad_out), .pad_oe_o (pad_oe),
    .pad_pu_o (pad_pu), .pad_pd_o (pad_pd), .pad_st_dis_o (pad_st),
    .filter_en_o (flt_en), .periph_out_i (p_out), .periph_oe_i (p_oe)
  );

  task automatic chk(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic wr(int a, logic [N-1:0] d);
    @(negedge clk);
    addr = AW'(a); wdata = d; we = 1;
    @(negedge clk);
    we = 0; wdata = '0;
  endtask

  task automatic rd(int a, output logic [N-1:0] d);
    addr = AW'(a);
    #2;
    d = rdata;
  endtask

  task automatic t_reset;
    logic [N-1:0] v;
    rd(A_OWN_R, v); chk("R1 own", v, '1);
    rd(A_OE_R, v);  chk("R1 oe", v, '0);
    rd(A_DO_R, v);  chk("R1 do", v, '0);
    rd(A_PU_R, v);  chk("R1 pu", v, '1);
    rd(A_PD_R, v);  chk("R1 pd", v, '0);
    rd(A_MD_R, v);  chk("R1 md", v, '0);
    rd(A_FL_R, v);  chk("R1 flt", v, '0);
    rd(A_SLO, v);   chk("R1 sel_lo", v, '0);
    rd(A_SHI, v);   chk("R1 sel_hi", v, '0);
    rd(A_SCH, v);   chk("R1 schmitt", v, '0);
    rd(A_PIN, v);   chk("R1 pin", v, '0);
    chk("R1 pad_oe", pad_oe, '0);
    chk("R1 pad_pu", pad_pu, '1);
  endtask

  task automatic t_setclr;
    logic [N-1:0] v;
    wr(A_OE_S, 32'h0000_00F0);
    rd(A_OE_R, v); chk("R2 oe set", v, 32'h0000_00F0);
    wr(A_OE_S, 32'h0000_0F00);
    rd(A_OE_R, v); chk("R2 oe set keep", v, 32'h0000_0FF0);
    wr(A_OE_C, 32'h0000_0030);
    rd(A_OE_R, v); chk("R2 oe clr", v, 32'h0000_0FC0);
    wr(A_OE_S, 32'h0);
    wr(A_OE_C, 32'h0);
    rd(A_OE_R, v); chk("R2 zero write", v, 32'h0000_0FC0);
    wr(A_DO_S, 32'h8000_0A40);
    rd(A_DO_R, v); chk("R2 do set", v, 32'h8000_0A40);
    chk("R5 pad_oe", pad_oe, 32'h0000_0FC0);
    chk("R5 pad_out", pad_out, 32'h8000_0A40);
    wr(A_FL_S, 32'h8000_0001);
    wr(A_FL_C, 32'h0000_0001);
    rd(A_FL_R, v); chk("R2 flt", v, 32'h8000_0000);
    chk("R2 filter_en_o", flt_en, 32'h8000_0000);
  endtask

  task automatic t_pull;
    logic [N-1:0] v;
    wr(A_PD_S, 32'h0000_FFFF);
    rd(A_PD_R, v); chk("R3 pd set", v, 32'h0000_FFFF);
    rd(A_PU_R, v); chk("R3 pu cleared by pd", v, 32'hFFFF_0000);
    wr(A_PU_S, 32'h0000_00FF);
    rd(A_PU_R, v); chk("R3 pu set", v, 32'hFFFF_00FF);
    rd(A_PD_R, v); chk("R3 pd cleared by pu", v, 32'h0000_FF00);
    chk("R3 pad_pu", pad_pu, 32'hFFFF_00FF);
    chk("R3 pad_pd", pad_pd, 32'h0000_FF00);
  endtask

  task automatic t_opendrain;
    wr(A_OE_C, '1);
    wr(A_DO_C, '1);
    wr(A_OE_S, 32'h0000_FF00);
    wr(A_DO_S, 32'h0000_3C3C);
    wr(A_MD_S, 32'h0000_F0F0);
    #1;
    chk("R6 pad_out", pad_out, 32'h0000_0C0C);
    chk("R6 pad_oe", pad_oe, 32'h0000_CF00);
  endtask

  task automatic t_periph;
    logic [N-1:0] v;
    p_out = {32'h8, 32'h4, 32'h2, 32'h1};
    p_oe  = {32'h8, 32'h4, 32'h2, 32'h1};
    wr(A_SLO, 32'h0000_000A);
    wr(A_SHI, 32'h0000_000C);
    wr(A_OWN_C, 32'h0000_000F);
    #1;
    chk("R4 pad_out codes", pad_out, 32'h0000_0C0F);
    chk("R4 pad_oe codes", pad_oe, 32'h0000_CF0F);
    wr(A_SLO, 32'h0000_000B);
    wr(A_SHI, 32'h0000_000D);
    #1;
    chk("R4 pin0 to D", pad_out, 32'h0000_0C0E);
    chk("R4 pin0 oe D", pad_oe, 32'h0000_CF0E);
    rd(A_SLO, v); chk("R8 sel_lo rb", v, 32'h0000_000B);
    rd(A_SHI, v); chk("R8 sel_hi rb", v, 32'h0000_000D);
  endtask

  task automatic t_sync;
    logic [N-1:0] v;
    @(negedge clk);
    pad_in = 32'hA5A5_0001;
    @(negedge clk);
    rd(A_PIN, v); chk("R7 one edge old", v, 32'h0);
    @(negedge clk);
    rd(A_PIN, v); chk("R7 two edges new", v, 32'hA5A5_0001);
  endtask

  task automatic t_misc;
    logic [N-1:0] v;
    wr(A_OE_R, '1);
    rd(A_OE_R, v); chk("R9 stat write ignored", v, 32'h0000_FF00);
    wr(A_PIN, 32'h0);
    rd(A_PIN, v); chk("R9 pin write ignored", v, 32'hA5A5_0001);
    rd(A_OE_S, v); chk("R9 set reads 0", v, 32'h0);
    rd(A_PU_C, v); chk("R9 clr reads 0", v, 32'h0);
    rd(30, v);     chk("R9 unmapped reads 0", v, 32'h0);
    wr(A_SCH, 32'h0000_1234);
    rd(A_SCH, v); chk("R8 schmitt rb", v, 32'h0000_1234);
    chk("R8 pad_st_dis", pad_st, 32'h0000_1234);
  endtask

  initial begin
    p_out = '0; p_oe = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_setclr;
    t_pull;
    t_opendrain;
    t_periph;
    t_sync;
    t_misc;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule